// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block keeps the pending-request bits for a bank of interrupt lines, eight by default. Each line is sampled every clock. A per-line trigger-mode bit decides how the sample is turned into a request. In edge mode, a low-to-high transition captures a request that stays pending until the acknowledge logic clears it. In level mode, the request simply follows the line.

A previous-level register, updated in both modes, provides the edge detection. The trigger-mode register is written as a whole word through a simple write port. A fixed per-instance mask limits which of its bits can ever be set, and the stored value can always be read back. The request vector is a registered output meant to feed a priority resolver. The acknowledge side returns a one-hot or multi-bit clear strobe.

Inputs are assumed to be synchronous to `clk` already. All state changes on the rising edge. Reset is synchronous and active high.

Top module: `irq_req_latch`

## Requirements
- R1: While reset is high at a rising edge, every request bit and every trigger-mode bit is 0 after that edge, so all lines start in edge mode.
- R2: A write stores `trig_wdata & WR_MASK` into the trigger-mode register at the clock edge, and `trig_rdata` shows the stored value from the next cycle on. Bit i belongs to line i, where 1 means level mode and 0 means edge mode. Bits that are 0 in `WR_MASK` always read 0.
- R3: For a line in level mode, the request bit after an edge equals the line's input at that edge.
- R4: For a line in level mode, the clear strobe has no effect on the request bit.
- R5: For a line in edge mode, an input that is high at an edge where the previous-level bit is 0 sets the request bit.
- R6: For a line in edge mode, an input that stays high does not capture again, so a cleared request stays clear until the input has been low for at least one edge.
- R7: For a line in edge mode, a low input does not clear a pending request.
- R8: For a line in edge mode, the clear strobe clears the request bit when no new rising edge arrives in the same cycle.
- R9: When a clear strobe and a new rising edge on an edge-mode line arrive in the same cycle, the request bit is 1 afterwards.
- R10: The previous-level bit is tracked in level mode too. A line switched from level mode to edge mode while its input is high does not capture a new request until the input falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| irq_lvl | input | NLINES | Synchronous interrupt line levels, bit i is line i |
| trig_wr | input | 1 | Write enable for the trigger-mode register |
| trig_wdata | input | NLINES | Write data for the trigger-mode register (1 = level, 0 = edge) |
| trig_rdata | output | NLINES | Stored trigger-mode value |
| ack_clr | input | NLINES | Per-line clear strobe from the acknowledge logic |
| req_pend | output | NLINES | Registered pending-request vector |

## Verification
The bench goes after the cycle where a clear strobe and a fresh rising edge meet. A design that lets the clear win would drop an interrupt there. It also tests the case of an input held high after acknowledge, where a design without a previous-level bit would fire the interrupt again and again. Level-mode lines receive clear strobes, which a careless design would honour and so lose a still-asserted level. Edge-mode lines see falling inputs, which a design that tracked the pin would wrongly let cancel a pending request. Every trigger-mode value is written, so masked bits that read back as 1 are caught. A line is also switched from level to edge mode while high, which exposes a design that updates the previous level only in edge mode.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/irq_trig_reg.sv
module irq_trig_reg #(
  parameter int              NLINES  = 8,
  parameter logic [NLINES-1:0] WR_MASK = 8'hED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [NLINES-1:0] wdata,
  output logic [NLINES-1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else if (wr) mode_q <= wdata & WR_MASK;
  end

  // R2: stored value is the masked write data
  p_masked_store_r2: assert property (@(posedge clk) disable iff (rst)
    wr |=> (mode_q == ($past(wdata) & WR_MASK)));
  // R2: contents hold without a write
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(mode_q));
  // R1: reset leaves all lines in edge mode
  p_mode_reset_r1: assert property (@(posedge clk) rst |=> (mode_q == '0));
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_latch_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  lvl,
  input  logic  clr,
  input  trig_e mode,
  output logic  req_q
);
  logic prev_q;
  logic rise;

  assign rise = lvl && !prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      if (mode == TRIG_LEVEL) req_q <= lvl;
      else if (rise)          req_q <= 1'b1;
      else if (clr)           req_q <= 1'b0;
    end
  end

  // R3: level-mode request follows the input
  p_level_follow_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == TRIG_LEVEL) |=> (req_q == $past(lvl)));
  // R4: clear strobe ignored on a high level-mode line
  p_level_noclr_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == TRIG_LEVEL && clr && lvl) |=> req_q);
  // R5 and R9: a rising edge in edge mode always captures
  p_edge_set_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == TRIG_EDGE && lvl && !prev_q) |=> req_q);
  // R7: a pending edge request survives without a clear
  p_edge_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == TRIG_EDGE && req_q && !clr) |=> req_q);
  // R8: clear without a new edge empties the request
  p_edge_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == TRIG_EDGE && clr && !(lvl && !prev_q)) |=> !req_q);
  // R6: a held-high line does not set a cleared request
  p_edge_noretrig_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == TRIG_EDGE && !req_q && prev_q) |=> !req_q);
  // R1: reset empties the request
  p_req_reset_r1: assert property (@(posedge clk) rst |=> !req_q);
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
#(
  parameter int                NLINES  = 8,
  parameter logic [NLINES-1:0] WR_MASK = 8'hED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] irq_lvl,
  input  logic              trig_wr,
  input  logic [NLINES-1:0] trig_wdata,
  output logic [NLINES-1:0] trig_rdata,
  input  logic [NLINES-1:0] ack_clr,
  output logic [NLINES-1:0] req_pend
);
  logic [NLINES-1:0] mode_vec;

  irq_trig_reg #(.NLINES(NLINES), .WR_MASK(WR_MASK)) u_trig (
    .clk   (clk),
    .rst   (rst),
    .wr    (trig_wr),
    .wdata (trig_wdata),
    .mode_q(mode_vec)
  );

  assign trig_rdata = mode_vec;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    irq_line_cell u_cell (
      .clk  (clk),
      .rst  (rst),
      .lvl  (irq_lvl[i]),
      .clr  (ack_clr[i]),
      .mode (trig_e'(mode_vec[i])),
      .req_q(req_pend[i])
    );
  end

  // R2: unwritable trigger bits never read as 1
  always @(posedge clk) begin
    if (!rst) p_mask_bits_r2: assert ((trig_rdata & ~WR_MASK) == '0);
  end
endmodule

// File: tb/sim_irq_req_latch.sv
module sim_irq_req_latch;
  localparam int              N    = 8;
  localparam logic [N-1:0]    MASK = 8'hED;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] irq_lvl = '0, trig_wdata = '0, ack_clr = '0;
  logic         trig_wr = 1'b0;
  logic [N-1:0] trig_rdata, req_pend;

  int errors = 0, checks = 0;
  logic [N-1:0] m_req = '0, m_prev = '0, m_mode = '0;
  logic [15:0]  lfsr = 16'hACE1;

  always #4 clk = ~clk;

  irq_req_latch #(.NLINES(N), .WR_MASK(MASK)) u0 (
    .clk(clk), .rst(rst), .irq_lvl(irq_lvl), .trig_wr(trig_wr),
    .trig_wdata(trig_wdata), .trig_rdata(trig_rdata),
    .ack_clr(ack_clr), .req_pend(req_pend)
  );

  function automatic string tag_of(logic m, logic in, logic c, logic p);
    if (m) return c ? "R4" : "R3";
    if (in && !p && c) return "R9";
    if (in && !p) return "R5";
    if (c) return "R8";
    if (!in) return "R7";
    return "R6";
  endfunction

  // one cycle: drive at negedge, expected state from requirements, check at next negedge
  task automatic cyc(input logic [N-1:0] in, input logic [N-1:0] c,
                     input logic w, input logic [N-1:0] wd, input string force_tag);
    logic [N-1:0] n_req, n_mode;
    string tg [N];
    irq_lvl = in; ack_clr = c; trig_wr = w; trig_wdata = wd;
    for (int i = 0; i < N; i++) begin
      tg[i] = (force_tag != "") ? force_tag : tag_of(m_mode[i], in[i], c[i], m_prev[i]);
      if (m_mode[i]) n_req[i] = in[i];
      else if (in[i] && !m_prev[i]) n_req[i] = 1'b1;
      else if (c[i]) n_req[i] = 1'b0;
      else n_req[i] = m_req[i];
    end
    n_mode = w ? (wd & MASK) : m_mode;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      checks++;
      if (req_pend[i] !== n_req[i]) begin
        errors++;
        $display("FAIL %s line %0d: req actual=%b expected=%b", tg[i], i, req_pend[i], n_req[i]);
      end
    end
    checks++;
    if (trig_rdata !== n_mode) begin
      errors++;
      $display("FAIL R2: trig_rdata actual=%h expected=%h", trig_rdata, n_mode);
    end
    m_req = n_req; m_prev = in; m_mode = n_mode;
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checks++;
    if (req_pend !== '0 || trig_rdata !== '0) begin
      errors++;
      $display("FAIL R1: req=%h mode=%h expected=00 00", req_pend, trig_rdata);
    end
    // R5, R6, R7, R8 on edge lines
    cyc(8'h0F, 8'h00, 0, 0, "R5");
    cyc(8'h0F, 8'h0F, 0, 0, "R6");
    cyc(8'h0F, 8'h00, 0, 0, "R6");
    cyc(8'h00, 8'h00, 0, 0, "R7");
    cyc(8'h03, 8'h01, 0, 0, "R9");
    cyc(8'h00, 8'h03, 0, 0, "R8");
    // R3, R4: level mode on writable lines
    cyc(8'h00, 8'h00, 1, 8'hFF, "R2");
    cyc(8'hFF, 8'hFF, 0, 0, "");
    cyc(8'hFF, 8'hFF, 0, 0, "R4");
    // R10: switch to edge while high, clear, stay high -> no capture
    cyc(8'hFF, 8'h00, 1, 8'h00, "R10");
    cyc(8'hFF, 8'hFF, 0, 0, "R8");
    cyc(8'hFF, 8'h00, 0, 0, "R10");
    cyc(8'h00, 8'h00, 0, 0, "R10");
    cyc(8'hFF, 8'h00, 0, 0, "R10");
    // sweep every trigger-mode value with pseudo-random lines and clears
    for (int m = 0; m < 256; m++) begin
      step_lfsr();
      cyc(lfsr[7:0], lfsr[15:8], 1, m[7:0], "");
      for (int k = 0; k < 32; k++) begin
        step_lfsr();
        cyc(lfsr[7:0], lfsr[15:8] & lfsr[11:4], 0, 0, "");
      end
    end
    // R1: reset mid-run clears everything
    rst = 1'b1; irq_lvl = '1; ack_clr = '0; trig_wr = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (req_pend !== '0 || trig_rdata !== '0) begin
      errors++;
      $display("FAIL R1: req=%h mode=%h expected=00 00", req_pend, trig_rdata);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule